// File: doc/BRIEF.md
# Precision-Scalable Radix-2 Butterfly Datapath

This block is the arithmetic core of a radix-2 decimation-in-time FFT stage. Each clock it can accept one butterfly: two complex operands A and B and a complex twiddle factor W. It returns X = (A + W·B)/2 and Y = (A − W·B)/2. All real and imaginary parts are 16-bit two's complement. The twiddle is in Q1.15 format. The halving at every stage keeps the magnitudes from growing across the transform.

The complex product is formed by four signed array multipliers of the Baugh-Wooley kind. A per-butterfly precision select can switch the datapath to 8-bit processing. In that mode the low byte of every operand is held at zero before it reaches the arithmetic, so only the upper byte toggles, and the low byte of both results reads zero. One set of hardware therefore serves both precisions. The precision select travels down the pipeline with its butterfly, so 8-bit and 16-bit work can be mixed cycle by cycle. Results leave three cycles after entry with a matching valid flag.

Top module: `prec_butterfly`

## Requirements
- R1: With `mode_8b`=0 and P = W·B rounded as in R2, each result part is X = floor((A + P)/2) and Y = floor((A − P)/2), computed per real and imaginary part and then limited as in R3.
- R2: The twiddle product parts are P_re = floor((B_re·W_re − B_im·W_im + 2^14) / 2^15) and P_im = floor((B_re·W_im + B_im·W_re + 2^14) / 2^15), which is a shift right by 15 with round-half-up.
- R3: A halved sum outside the range −32768 to 32767 saturates to the nearest bound.
- R4: With `mode_8b`=1, bits 7:0 of every A, B and W part are treated as zero, and bits 7:0 of every X and Y part are driven zero after saturation.
- R5: `out_valid` equals `in_valid` from exactly three cycles earlier, and the results of that butterfly appear in the same cycle.
- R6: While `out_valid` is 0, the four result ports hold the values of the most recent valid result, or zero if there has been none since reset.
- R7: Synchronous active-high `rst` clears the pipeline. In the cycle after reset, `out_valid` is 0 and all results are 0, and butterflies in flight are discarded.
- R8: The precision select is sampled with each butterfly. Back-to-back butterflies in different modes each follow their own mode.
- R9: Full-scale negative operands (−32768 in B and W) produce the exact signed products. For example, B_re = W_re = −32768 with the imaginary parts zero gives P_re = 32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A butterfly is presented this cycle |
| mode_8b | input | 1 | 1 = 8-bit precision, 0 = 16-bit |
| a_re | input | 16 | Operand A real part |
| a_im | input | 16 | Operand A imaginary part |
| b_re | input | 16 | Operand B real part |
| b_im | input | 16 | Operand B imaginary part |
| w_re | input | 16 | Twiddle real part, Q1.15 |
| w_im | input | 16 | Twiddle imaginary part, Q1.15 |
| out_valid | output | 1 | Results valid this cycle |
| x_re | output | 16 | Sum output real part |
| x_im | output | 16 | Sum output imaginary part |
| y_re | output | 16 | Difference output real part |
| y_im | output | 16 | Difference output imaginary part |

## Verification
The bench includes a product whose fraction is exactly one half, with an A chosen so that the halving does not hide the difference. A design that truncates instead of rounding returns a result one lower. Multiplying −32768 by −32768 exercises the sign-bit terms of the array. A wrong inversion or a missing correction constant there gives a large negative product, and the sum then saturates toward the wrong rail. Alternating 8-bit and 16-bit butterflies on consecutive cycles catch a precision flag that is not pipelined with its data: the low bytes would be wrongly zeroed or left live on the neighbouring result. A reset in the middle of a stream catches valid bits that survive reset, and idle gaps catch outputs that fail to hold their last value.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    parameter int unsigned DW     = 16;
    parameter int unsigned NARROW = 8;

    localparam int unsigned PW   = 2 * DW;
    localparam int unsigned FRAC = DW - 1;
    localparam int unsigned SUMW = PW + 1;
    localparam int unsigned PRW  = SUMW - FRAC;
    localparam int unsigned HW   = PRW + 1;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [PRW-1:0] re;
        logic signed [PRW-1:0] im;
    } cprod_t;

    function automatic logic [DW-1:0] low_mask(input logic narrow);
        logic [DW-1:0] m;
        m = '1;
        if (narrow) m[DW-NARROW-1:0] = '0;
        return m;
    endfunction

    function automatic cplx_t gate_cplx(input cplx_t v, input logic narrow);
        cplx_t r;
        r.re = v.re & low_mask(narrow);
        r.im = v.im & low_mask(narrow);
        return r;
    endfunction

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [PRW-1:0] v);
        logic [PRW-DW:0] top;
        top = v[PRW-1:DW-1];
        if ((&top) || !(|top))
            return v[DW-1:0];
        else if (v[PRW-1])
            return {1'b1, {(DW-1){1'b0}}};
        else
            return {1'b0, {(DW-1){1'b1}}};
    endfunction

endpackage

// File: rtl/bfly_bw_mult.sv
module bfly_bw_mult #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam logic [2*N-1:0] CORR =
        ({{(N-1){1'b0}}, 1'b1, {N{1'b0}}}) | ({1'b1, {(2*N-1){1'b0}}});

    logic [2*N-1:0] row [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        always_comb begin
            logic t;
            row[i] = '0;
            for (int j = 0; j < N; j++) begin
                t = a[i] & b[j];
                if ((i == N-1) != (j == N-1)) t = ~t;
                row[i][i+j] = t;
            end
        end
    end

    always_comb begin
        logic [2*N-1:0] acc;
        acc = CORR;
        for (int i = 0; i < N; i++) acc = acc + row[i];
        p = acc;
    end
endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul
    import bfly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en1,
    input  logic   en2,
    input  logic   narrow_in,
    input  cplx_t  a_in,
    input  cplx_t  b_in,
    input  cplx_t  w_in,
    output logic   narrow_out,
    output cplx_t  a_out,
    output cprod_t p_out
);
    localparam int unsigned NM = 4;
    localparam logic signed [SUMW-1:0] HALF = SUMW'(1) <<< (FRAC - 1);

    logic [DW-1:0] mx [NM];
    logic [DW-1:0] my [NM];
    logic [PW-1:0] mp [NM];
    logic [PW-1:0] pp_q [NM];
    cplx_t a_s1;
    logic  nar_s1;

    assign mx[0] = b_in.re;  assign my[0] = w_in.re;
    assign mx[1] = b_in.im;  assign my[1] = w_in.im;
    assign mx[2] = b_in.re;  assign my[2] = w_in.im;
    assign mx[3] = b_in.im;  assign my[3] = w_in.re;

    for (genvar k = 0; k < NM; k++) begin : g_mul
        bfly_bw_mult #(.N(DW)) u_mul (
            .a (mx[k]),
            .b (my[k]),
            .p (mp[k])
        );
        always_ff @(posedge clk) begin
            if (rst)      pp_q[k] <= '0;
            else if (en1) pp_q[k] <= mp[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_s1   <= '0;
            nar_s1 <= 1'b0;
        end else if (en1) begin
            a_s1   <= a_in;
            nar_s1 <= narrow_in;
        end
    end

    logic signed [SUMW-1:0] sum_re, sum_im;
    always_comb begin
        sum_re = SUMW'($signed(pp_q[0])) - SUMW'($signed(pp_q[1])) + HALF;
        sum_im = SUMW'($signed(pp_q[2])) + SUMW'($signed(pp_q[3])) + HALF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_out      <= '0;
            a_out      <= '0;
            narrow_out <= 1'b0;
        end else if (en2) begin
            p_out.re   <= sum_re[SUMW-1:FRAC];
            p_out.im   <= sum_im[SUMW-1:FRAC];
            a_out      <= a_s1;
            narrow_out <= nar_s1;
        end
    end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   narrow,
    input  cplx_t  a,
    input  cprod_t p,
    output cplx_t  x,
    output cplx_t  y
);
    function automatic logic signed [DW-1:0] half_sat(
        input logic signed [DW-1:0]  av,
        input logic signed [PRW-1:0] pv,
        input logic                  sub,
        input logic                  nar
    );
        logic signed [HW-1:0] s;
        logic signed [DW-1:0] r;
        if (sub) s = HW'(av) - HW'(pv);
        else     s = HW'(av) + HW'(pv);
        r = sat_dw(s[HW-1:1]);
        return r & low_mask(nar);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
            y <= '0;
        end else if (en) begin
            x.re <= half_sat(a.re, p.re, 1'b0, narrow);
            x.im <= half_sat(a.im, p.im, 1'b0, narrow);
            y.re <= half_sat(a.re, p.re, 1'b1, narrow);
            y.im <= half_sat(a.im, p.im, 1'b1, narrow);
        end
    end
endmodule

// File: rtl/prec_butterfly.sv
module prec_butterfly
    import bfly_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          mode_8b,
    input  logic [15:0]   a_re,
    input  logic [15:0]   a_im,
    input  logic [15:0]   b_re,
    input  logic [15:0]   b_im,
    input  logic [15:0]   w_re,
    input  logic [15:0]   w_im,
    output logic          out_valid,
    output logic [15:0]   x_re,
    output logic [15:0]   x_im,
    output logic [15:0]   y_re,
    output logic [15:0]   y_im
);
    localparam int unsigned STAGES = 3;

    cplx_t  a_g, b_g, w_g;
    cplx_t  a_mid, x_q, y_q;
    cprod_t p_mid;
    logic   nar_mid;
    logic [STAGES-1:0] vpipe;

    assign a_g = gate_cplx('{re: a_re, im: a_im}, mode_8b);
    assign b_g = gate_cplx('{re: b_re, im: b_im}, mode_8b);
    assign w_g = gate_cplx('{re: w_re, im: w_im}, mode_8b);

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[STAGES-2:0], in_valid};
    end

    bfly_cmul u_cmul (
        .clk        (clk),
        .rst        (rst),
        .en1        (in_valid),
        .en2        (vpipe[0]),
        .narrow_in  (mode_8b),
        .a_in       (a_g),
        .b_in       (b_g),
        .w_in       (w_g),
        .narrow_out (nar_mid),
        .a_out      (a_mid),
        .p_out      (p_mid)
    );

    bfly_addsub u_addsub (
        .clk    (clk),
        .rst    (rst),
        .en     (vpipe[1]),
        .narrow (nar_mid),
        .a      (a_mid),
        .p      (p_mid),
        .x      (x_q),
        .y      (y_q)
    );

    assign out_valid = vpipe[STAGES-1];
    assign x_re = x_q.re;
    assign x_im = x_q.im;
    assign y_re = y_q.re;
    assign y_im = y_q.im;
endmodule

// File: rtl/bfly_checker.sv
module bfly_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        mode_8b,
    input logic        out_valid,
    input logic [15:0] x_re,
    input logic [15:0] x_im,
    input logic [15:0] y_re,
    input logic [15:0] y_im
);
    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    assign warm = (since_rst == 2'd3);

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 3)));

    assert_low_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && $past(mode_8b, 3) && $past(in_valid, 3)) |->
        (x_re[7:0] == 8'h00 && x_im[7:0] == 8'h00 &&
         y_re[7:0] == 8'h00 && y_im[7:0] == 8'h00));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |->
        ($stable(x_re) && $stable(x_im) && $stable(y_re) && $stable(y_im)));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (!out_valid && x_re == 16'h0 && x_im == 16'h0 &&
                 y_re == 16'h0 && y_im == 16'h0));
endmodule

bind prec_butterfly bfly_checker u_bfly_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode_8b   (mode_8b),
    .out_valid (out_valid),
    .x_re      (x_re),
    .x_im      (x_im),
    .y_re      (y_re),
    .y_im      (y_im)
);

// File: tb/sim_prec_butterfly.sv
`timescale 1ns/1ps
module sim_prec_butterfly;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic mode_8b = 1'b0;
    logic [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, w_re = '0, w_im = '0;
    logic out_valid;
    logic [15:0] x_re, x_im, y_re, y_im;

    always #2 clk = ~clk;

    prec_butterfly u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_8b(mode_8b),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .out_valid(out_valid),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model pipeline: index 0 newest, 2 oldest
    logic        hv   [3];
    logic [15:0] hres [3][4];
    string       htag [3];
    logic [15:0] held [4];

    // {mode, a_re, a_im, b_re, b_im, w_re, w_im}
    localparam logic [96:0] VEC [12] = '{
        {1'b0, 16'sd1000,  16'sd2000,  16'sd3000,  -16'sd4000, 16'sd23170, -16'sd23170},
        {1'b0, -16'sd5000, 16'sd7000,  16'sd12345, 16'sd321,   16'sd32767, 16'sd0},
        {1'b0, 16'sd0,     16'sd0,     -16'sd1,    16'sd1,     16'sd0,     16'sd32767},
        {1'b0, 16'sd32767, -16'sd32768, 16'sd100,  16'sd200,   -16'sd12000, 16'sd30000},
        {1'b0, 16'sd1234,  -16'sd4321, -16'sd20000, 16'sd15000, 16'sd18000, 16'sd18000},
        {1'b0, -16'sd77,   16'sd88,    16'sd99,    -16'sd111,  -16'sd32768, 16'sd0},
        {1'b1, 16'h12ab,   16'hf3cd,   16'h7f55,   16'h80aa,   16'h5a82,   16'ha57e},
        {1'b1, 16'h4000,   16'hc0ff,   16'h2233,   16'h4455,   16'h7fff,   16'h0000},
        {1'b1, 16'h7fff,   16'h7fff,   16'h7fff,   16'h7fff,   16'h7fff,   16'h7fff},
        {1'b0, 16'sd3,     -16'sd3,    16'sd3,     16'sd5,     16'sd16384, 16'sd16384},
        {1'b1, 16'h0101,   16'hfefe,   16'h8001,   16'h00ff,   16'h8000,   16'h40c0},
        {1'b0, 16'sd22222, 16'sd11111, 16'sd30000, 16'sd30000, 16'sd23170, 16'sd23170}
    };

    function automatic longint fl_div2(input longint v);
        return v >>> 1;
    endfunction

    function automatic logic [15:0] lim16(input longint v);
        if (v > 32767)  return 16'h7fff;
        if (v < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    function automatic longint sx(input logic [15:0] v, input logic m);
        longint r;
        r = longint'($signed(v));
        if (m) r = r & ~longint'(255);
        return r;
    endfunction

    task automatic ref_model(input logic m,
                             input logic [15:0] ar, ai, br, bi, wr, wi,
                             output logic [15:0] r [4]);
        longint a0, a1, b0, b1, w0, w1, p0, p1;
        a0 = sx(ar, m); a1 = sx(ai, m);
        b0 = sx(br, m); b1 = sx(bi, m);
        w0 = sx(wr, m); w1 = sx(wi, m);
        p0 = (b0 * w0 - b1 * w1 + 16384) >>> 15;
        p1 = (b0 * w1 + b1 * w0 + 16384) >>> 15;
        r[0] = lim16(fl_div2(a0 + p0));
        r[1] = lim16(fl_div2(a1 + p1));
        r[2] = lim16(fl_div2(a0 - p0));
        r[3] = lim16(fl_div2(a1 - p1));
        if (m) for (int i = 0; i < 4; i++) r[i][7:0] = 8'h00;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; htag[i] = "R6";
            for (int k = 0; k < 4; k++) hres[i][k] = '0;
        end
        for (int k = 0; k < 4; k++) held[k] = '0;
    endtask

    task automatic check_outputs();
        logic [15:0] act [4];
        logic [15:0] exp [4];
        act[0] = x_re; act[1] = x_im; act[2] = y_re; act[3] = y_im;
        chk("R5", "out_valid", {15'd0, out_valid}, {15'd0, hv[2]});
        if (hv[2]) for (int k = 0; k < 4; k++) held[k] = hres[2][k];
        for (int k = 0; k < 4; k++) exp[k] = held[k];
        chk(hv[2] ? htag[2] : "R6", "x_re", act[0], exp[0]);
        chk(hv[2] ? htag[2] : "R6", "x_im", act[1], exp[1]);
        chk(hv[2] ? htag[2] : "R6", "y_re", act[2], exp[2]);
        chk(hv[2] ? htag[2] : "R6", "y_im", act[3], exp[3]);
    endtask

    task automatic step(input logic v, input logic m,
                        input logic [15:0] ar, ai, br, bi, wr, wi,
                        input string tag);
        logic [15:0] r [4];
        @(negedge clk);
        check_outputs();
        hv[2] = hv[1]; htag[2] = htag[1];
        hv[1] = hv[0]; htag[1] = htag[0];
        for (int k = 0; k < 4; k++) begin
            hres[2][k] = hres[1][k];
            hres[1][k] = hres[0][k];
        end
        ref_model(m, ar, ai, br, bi, wr, wi, r);
        hv[0] = v; htag[0] = tag;
        for (int k = 0; k < 4; k++) hres[0][k] = r[k];
        in_valid = v; mode_8b = m;
        a_re = ar; a_im = ai; b_re = br; b_im = bi; w_re = wr; w_im = wi;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            step(1'b0, 1'b0, 16'h5555, 16'haaaa, 16'h1234, 16'h4321, 16'h7fff, 16'h7fff, "R6");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        clear_model();
        chk("R7", "out_valid after reset", {15'd0, out_valid}, 16'd0);
        chk("R7", "x_re after reset", x_re, 16'd0);
        chk("R7", "y_im after reset", y_im, 16'd0);
        rst = 1'b0;
    endtask

    initial begin
        clear_model();
        do_reset();

        // R1/R4: table walk, one butterfly per cycle
        for (int i = 0; i < 12; i++) begin
            logic [96:0] e;
            e = VEC[i];
            step(1'b1, e[96], e[95:80], e[79:64], e[63:48], e[47:32], e[31:16], e[15:0],
                 e[96] ? "R4" : "R1");
        end
        idle(4);

        // R2: exact half rounds up (B_re=1, W_re=0.5, A_re=1 -> X_re=1, Y_re=0)
        step(1'b1, 1'b0, 16'sd1, 16'sd2, 16'sd1, 16'sd0, 16'sd16384, 16'sd0, "R2");
        step(1'b1, 1'b0, 16'sd2, 16'sd2, -16'sd1, 16'sd0, 16'sd16384, 16'sd0, "R2");
        idle(3);

        // R3: saturation both rails
        step(1'b1, 1'b0, 16'sd32767, -16'sd32768, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767, "R3");
        step(1'b1, 1'b0, -16'sd32768, 16'sd32767, 16'sd32767, -16'sd32768, -16'sd32768, 16'sd23170, "R3");
        idle(3);

        // R9: full-scale negative operands
        step(1'b1, 1'b0, 16'sd0, 16'sd0, -16'sd32768, 16'sd0, -16'sd32768, 16'sd0, "R9");
        step(1'b1, 1'b0, 16'sd100, 16'sd0, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768, "R9");
        step(1'b1, 1'b0, -16'sd32768, -16'sd32768, -16'sd32768, 16'sd1, 16'sd1, -16'sd32768, "R9");
        idle(3);

        // R8: alternating precision on consecutive cycles
        for (int i = 0; i < 6; i++)
            step(1'b1, i[0], 16'h1357 + 16'(i * 97), 16'h2468, 16'h3c3c, 16'hc3c3,
                 16'h5a82, 16'ha57e, "R8");
        idle(3);

        // R6: gaps between valid butterflies hold the last result
        step(1'b1, 1'b0, 16'sd900, 16'sd800, 16'sd700, 16'sd600, 16'sd20000, -16'sd9000, "R6");
        idle(2);
        step(1'b1, 1'b1, 16'h7123, 16'h8123, 16'h0a0a, 16'hf0f0, 16'h4000, 16'h4000, "R6");
        idle(5);

        // R7: reset in the middle of a stream discards work in flight
        step(1'b1, 1'b0, 16'sd111, 16'sd222, 16'sd333, 16'sd444, 16'sd555, 16'sd666, "R7");
        step(1'b1, 1'b0, 16'sd777, 16'sd888, 16'sd999, 16'sd1111, 16'sd1222, 16'sd1333, "R7");
        do_reset();
        idle(4);

        // R5: sparse valid pattern after reset
        step(1'b1, 1'b0, -16'sd3000, 16'sd3000, 16'sd4000, -16'sd4000, 16'sd23170, 16'sd23170, "R5");
        idle(1);
        step(1'b1, 1'b1, 16'h3f80, 16'hc080, 16'h6100, 16'h9f00, 16'h7fff, 16'h8000, "R5");
        idle(5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule